// File: doc/BRIEF.md
# Network interface wakeup and control decoder

This block is the controller-facing control logic of a full-duplex serial network interface. A controller issues start commands. Two bits of each start command select one of three wakeup sources: a control request, an input start, or an output start. The output start also enables the output machine. The serial datapaths are outside the block. They report an output word request and an input word arrival through strobes, and each report raises a further wakeup. The block asserts a single wakeup line while any source is pending. Beside it, a 2-bit dispatch code names the most urgent cause, so the controller can branch straight to the matching handler.

A separate control-word strobe carries configuration and housekeeping commands. These are: master reset, marking the current output word as the last one, loopback on and off, the host-ready relay on and off, discard mode on and off, and an attempt to clear the sticky network-down flag. A 16-bit status word is always presented. It carries that sticky flag, the live network-ready state and the relay state, and every other bit reads as 1.

All inputs are single-cycle strobes or plain levels that are sampled on the rising clock edge. Every registered effect is visible in the cycle after the edge that sampled it. There is no back-pressure: each strobe acts in the cycle it is seen, so no valid/ready pair is needed.

Top module: `nif_ctl`

## Requirements
- R1: When `start_valid` is high, bits 10:9 of `start_word` select an action. 2'b11 makes the control wakeup pending (dispatch 2'b01). 2'b10 makes the input-start wakeup pending (dispatch 2'b00). 2'b01 sets `out_en` and makes the output wakeup pending (dispatch 2'b10). 2'b00 does nothing. Each action is visible one cycle later.
- R2: `wake` is the OR of all pending sources. `disp` gives the pending source in the fixed order input data (2'b11), then output request (2'b10), then control (2'b01), then input start (2'b00). `disp` is 2'b00 when nothing is pending.
- R3: `wake_clr` clears only the control and input-start wakeups. The output and input-data wakeups are left as they are.
- R4: `out_req` makes the output wakeup pending only while `out_en` is high, and `out_clr` clears that wakeup. `in_word` makes the input-data wakeup pending and `in_ack` clears it. For any source, a clear in the same cycle as a set wins.
- R5: Control word 1 is a master reset. It clears every pending wakeup, `out_en` and `last_word`, and pulses `xfer_stop` high for exactly one cycle. It leaves `host_relay`, `loopback`, `discard` and the sticky down flag unchanged. Control word 0 has no effect.
- R6: Control word 2 sets `last_word`. Only the master reset clears it.
- R7: Control words 4 and 5 turn `loopback` on and off. Control words 6 and 7 turn `host_relay` on and off.
- R8: Control word 16'h0400 turns `discard` on. Control word 16'h0200 turns it off.
- R9: The sticky down flag is set in every cycle that samples `net_ready` low. Control word 3 clears it only when `net_ready` is high in the same cycle. Otherwise the flag stays set.
- R10: `stat_word` follows the current state without delay. Bit 2 is the sticky down flag, bit 1 is the inverse of `net_ready`, bit 0 is the inverse of `host_relay`, and bits 15:3 are 1.
- R11: A control word with any value other than those listed in R5 to R9 changes no output.
- R12: After reset, nothing is pending and `out_en`, `last_word`, `loopback`, `host_relay`, `discard`, `xfer_stop` and the down flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Start command strobe |
| start_word | input | 16 | Start command word; bits 10:9 select the action |
| ctl_valid | input | 1 | Control word strobe |
| ctl_word | input | 16 | Control word |
| wake_clr | input | 1 | Clears the control and input-start wakeups |
| out_req | input | 1 | Output datapath asks for the next word |
| out_clr | input | 1 | Clears the output wakeup |
| in_word | input | 1 | Input datapath has a word available |
| in_ack | input | 1 | Clears the input-data wakeup |
| net_ready | input | 1 | Network ready level |
| wake | output | 1 | Any wakeup pending |
| disp | output | 2 | Dispatch code of the highest-priority pending source |
| out_en | output | 1 | Output machine enabled |
| xfer_stop | output | 1 | One-cycle pulse that stops both datapaths |
| last_word | output | 1 | Current output word is the last one |
| loopback | output | 1 | Loopback enabled |
| host_relay | output | 1 | Host-ready relay on |
| discard | output | 1 | Discard mode on |
| stat_word | output | 16 | Status word |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, the start field at bit 9, the discard controls at bits 10 and 9, and the status flags in bits 2 to 0. With these values every defined control code can be issued alongside arbitrary undefined ones. Directed steps cover the cases a random mix rarely lines up, among them the priority among all four sources, `wake_clr` with the output wakeup pending, and a clear attempt on the down flag while the network is still down. Long seeded random runs then overlap strobes with master resets and clears against sets in the same cycle.

// File: rtl/nif_ctl_pkg.sv
package nif_ctl_pkg;

  localparam int NSRC = 4;
  localparam int DSP_W = $clog2(NSRC);

  // source index equals its dispatch code
  typedef enum logic [1:0] {
    DSP_IN_START = 2'b00,
    DSP_CTRL     = 2'b01,
    DSP_OUT_REQ  = 2'b10,
    DSP_IN_DATA  = 2'b11
  } disp_e;

  typedef struct packed {
    logic mreset;
    logic last_set;
    logic try_clr_down;
    logic lb_on;
    logic lb_off;
    logic rly_on;
    logic rly_off;
    logic dis_on;
    logic dis_off;
  } ctl_act_t;

endpackage

// File: rtl/nif_cmd_dec.sv
module nif_cmd_dec
  import nif_ctl_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int START_LSB   = 9,
  parameter int DIS_ON_BIT  = 10,
  parameter int DIS_OFF_BIT = 9
) (
  input  logic             start_valid,
  input  logic [BUS_W-1:0] start_word,
  input  logic             ctl_valid,
  input  logic [BUS_W-1:0] ctl_word,
  output logic             go_in_start,
  output logic             go_ctrl,
  output logic             go_out,
  output ctl_act_t         act
);

  localparam logic [BUS_W-1:0] W_NOP    = BUS_W'(0);
  localparam logic [BUS_W-1:0] W_MRST   = BUS_W'(1);
  localparam logic [BUS_W-1:0] W_LAST   = BUS_W'(2);
  localparam logic [BUS_W-1:0] W_TRYCLR = BUS_W'(3);
  localparam logic [BUS_W-1:0] W_LBON   = BUS_W'(4);
  localparam logic [BUS_W-1:0] W_LBOFF  = BUS_W'(5);
  localparam logic [BUS_W-1:0] W_RLYON  = BUS_W'(6);
  localparam logic [BUS_W-1:0] W_RLYOFF = BUS_W'(7);
  localparam logic [BUS_W-1:0] W_DISON  = BUS_W'(1) << DIS_ON_BIT;
  localparam logic [BUS_W-1:0] W_DISOFF = BUS_W'(1) << DIS_OFF_BIT;

  logic [1:0] sel;
  assign sel = start_word[START_LSB+1:START_LSB];

  always_comb begin
    go_in_start = 1'b0;
    go_ctrl     = 1'b0;
    go_out      = 1'b0;
    if (start_valid) begin
      unique case (sel)
        2'b11:   go_ctrl     = 1'b1;
        2'b10:   go_in_start = 1'b1;
        2'b01:   go_out      = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    act = '0;
    if (ctl_valid) begin
      case (ctl_word)
        W_NOP:    ;
        W_MRST:   act.mreset       = 1'b1;
        W_LAST:   act.last_set     = 1'b1;
        W_TRYCLR: act.try_clr_down = 1'b1;
        W_LBON:   act.lb_on        = 1'b1;
        W_LBOFF:  act.lb_off       = 1'b1;
        W_RLYON:  act.rly_on       = 1'b1;
        W_RLYOFF: act.rly_off      = 1'b1;
        W_DISON:  act.dis_on       = 1'b1;
        W_DISOFF: act.dis_off      = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/nif_wake_arb.sv
module nif_wake_arb
  import nif_ctl_pkg::*;
#(
  parameter int N  = NSRC,
  localparam int DW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set,
  input  logic [N-1:0]  clr,
  output logic [N-1:0]  pend,
  output logic          wake,
  output logic [DW-1:0] disp
);

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (clr[i]) pend[i] <= 1'b0;
      else if (set[i]) pend[i] <= 1'b1;
    end

    // R4: clear beats set
    a_r4_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !pend[i]);
    // R1: an unopposed set is pending next cycle
    a_r1_set_pends: assert property (@(posedge clk) disable iff (!rst_n)
      (set[i] && !clr[i]) |=> pend[i]);
  end

  assign wake = |pend;

  // highest index has priority
  always_comb begin
    disp = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) disp = DW'(i);
    end
  end

  // R2: top source always wins the dispatch
  a_r2_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend[N-1] |-> (disp == DW'(N-1)));
  a_r2_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |-> (disp == '0));

endmodule

// File: rtl/nif_link_stat.sv
module nif_link_stat
  import nif_ctl_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int WD_BIT = 2,
  parameter int NR_BIT = 1,
  parameter int HR_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_act_t         act,
  input  logic             net_ready,
  output logic             last_word,
  output logic             loopback,
  output logic             host_relay,
  output logic             discard,
  output logic             xfer_stop,
  output logic [BUS_W-1:0] stat_word
);

  logic was_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_word  <= 1'b0;
      loopback   <= 1'b0;
      host_relay <= 1'b0;
      discard    <= 1'b0;
      xfer_stop  <= 1'b0;
      was_down   <= 1'b0;
    end else begin
      xfer_stop <= act.mreset;
      if (act.mreset)        last_word <= 1'b0;
      else if (act.last_set) last_word <= 1'b1;
      if (act.lb_on)         loopback  <= 1'b1;
      else if (act.lb_off)   loopback  <= 1'b0;
      if (act.rly_on)        host_relay <= 1'b1;
      else if (act.rly_off)  host_relay <= 1'b0;
      if (act.dis_on)        discard   <= 1'b1;
      else if (act.dis_off)  discard   <= 1'b0;
      if (!net_ready)             was_down <= 1'b1;
      else if (act.try_clr_down)  was_down <= 1'b0;
    end
  end

  for (genvar b = 0; b < BUS_W; b++) begin : g_stat
    if (b == WD_BIT) begin : g_wd
      assign stat_word[b] = was_down;
    end else if (b == NR_BIT) begin : g_nr
      assign stat_word[b] = ~net_ready;
    end else if (b == HR_BIT) begin : g_hr
      assign stat_word[b] = ~host_relay;
    end else begin : g_one
      assign stat_word[b] = 1'b1;
    end
  end

  // R9: a down network always latches the flag
  a_r9_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !net_ready |=> was_down);
  // R9: no clear attempt, no clearing
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (was_down && !act.try_clr_down) |=> was_down);
  // R5: master reset leaves the relay alone
  a_r5_relay_kept: assert property (@(posedge clk) disable iff (!rst_n)
    act.mreset |=> $stable(host_relay));
  // R5: stop pulse lasts one cycle
  a_r5_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stop && !act.mreset) |=> !xfer_stop);

endmodule

// File: rtl/nif_ctl.sv
module nif_ctl
  import nif_ctl_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int START_LSB   = 9,
  parameter int DIS_ON_BIT  = 10,
  parameter int DIS_OFF_BIT = 9,
  parameter int WD_BIT      = 2,
  parameter int NR_BIT      = 1,
  parameter int HR_BIT      = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic [BUS_W-1:0] start_word,
  input  logic             ctl_valid,
  input  logic [BUS_W-1:0] ctl_word,
  input  logic             wake_clr,
  input  logic             out_req,
  input  logic             out_clr,
  input  logic             in_word,
  input  logic             in_ack,
  input  logic             net_ready,
  output logic             wake,
  output logic [1:0]       disp,
  output logic             out_en,
  output logic             xfer_stop,
  output logic             last_word,
  output logic             loopback,
  output logic             host_relay,
  output logic             discard,
  output logic [BUS_W-1:0] stat_word
);

  logic     go_in_start, go_ctrl, go_out;
  ctl_act_t act;
  logic [NSRC-1:0] set, clr, pend;

  nif_cmd_dec #(
    .BUS_W(BUS_W), .START_LSB(START_LSB),
    .DIS_ON_BIT(DIS_ON_BIT), .DIS_OFF_BIT(DIS_OFF_BIT)
  ) u_dec (
    .start_valid(start_valid), .start_word(start_word),
    .ctl_valid(ctl_valid), .ctl_word(ctl_word),
    .go_in_start(go_in_start), .go_ctrl(go_ctrl), .go_out(go_out),
    .act(act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          out_en <= 1'b0;
    else if (act.mreset) out_en <= 1'b0;
    else if (go_out)     out_en <= 1'b1;
  end

  always_comb begin
    set = '0;
    clr = '0;
    set[DSP_IN_START] = go_in_start;
    set[DSP_CTRL]     = go_ctrl;
    set[DSP_OUT_REQ]  = go_out | (out_req & out_en);
    set[DSP_IN_DATA]  = in_word;
    clr[DSP_IN_START] = wake_clr | act.mreset;
    clr[DSP_CTRL]     = wake_clr | act.mreset;
    clr[DSP_OUT_REQ]  = out_clr  | act.mreset;
    clr[DSP_IN_DATA]  = in_ack   | act.mreset;
  end

  nif_wake_arb #(.N(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .set(set), .clr(clr),
    .pend(pend), .wake(wake), .disp(disp)
  );

  nif_link_stat #(
    .BUS_W(BUS_W), .WD_BIT(WD_BIT), .NR_BIT(NR_BIT), .HR_BIT(HR_BIT)
  ) u_stat (
    .clk(clk), .rst_n(rst_n), .act(act), .net_ready(net_ready),
    .last_word(last_word), .loopback(loopback), .host_relay(host_relay),
    .discard(discard), .xfer_stop(xfer_stop), .stat_word(stat_word)
  );

  // R3: the wakeup strobe spares the output source
  a_r3_out_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[DSP_OUT_REQ] && wake_clr && !out_clr && !act.mreset) |=> pend[DSP_OUT_REQ]);
  // R4: requests while disabled raise nothing
  a_r4_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend[DSP_OUT_REQ] && out_req && !out_en && !go_out) |=> !pend[DSP_OUT_REQ]);
  // R5: master reset empties everything
  a_r5_mreset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    act.mreset |=> (!wake && !out_en && !last_word));

endmodule

// File: tb/nif_ctl_test.sv
`timescale 1ns/1ps
module nif_ctl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 0, ctl_valid = 0, wake_clr = 0, out_req = 0, out_clr = 0;
  logic in_word = 0, in_ack = 0, net_ready = 1;
  logic [15:0] start_word = 0, ctl_word = 0;
  logic wake, out_en, xfer_stop, last_word, loopback, host_relay, discard;
  logic [1:0] disp;
  logic [15:0] stat_word;

  always #4 clk = ~clk;

  nif_ctl uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_word(start_word),
    .ctl_valid(ctl_valid), .ctl_word(ctl_word), .wake_clr(wake_clr),
    .out_req(out_req), .out_clr(out_clr), .in_word(in_word), .in_ack(in_ack),
    .net_ready(net_ready), .wake(wake), .disp(disp), .out_en(out_en),
    .xfer_stop(xfer_stop), .last_word(last_word), .loopback(loopback),
    .host_relay(host_relay), .discard(discard), .stat_word(stat_word)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state, index = dispatch code
  logic [3:0] m_p = 0;
  logic m_oen = 0, m_last = 0, m_lb = 0, m_rly = 0, m_dis = 0, m_wd = 0, m_stop = 0;

  function automatic logic [1:0] exp_disp(logic [3:0] p);
    if (p[3]) return 2'd3;
    if (p[2]) return 2'd2;
    if (p[1]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [15:0] exp_stat(logic wd, logic nr, logic rly);
    return {13'h1FFF, wd, ~nr, ~rly};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic mr, cv;
    logic [1:0] f;
    logic [3:0] s, c;
    mr = ctl_valid && ctl_word == 16'd1;
    cv = start_valid;
    f  = start_word[10:9];
    s[0] = cv && f == 2'b10;
    s[1] = cv && f == 2'b11;
    s[2] = (cv && f == 2'b01) || (out_req && m_oen);
    s[3] = in_word;
    c[0] = wake_clr || mr;
    c[1] = wake_clr || mr;
    c[2] = out_clr || mr;
    c[3] = in_ack || mr;
    for (int i = 0; i < 4; i++) m_p[i] = c[i] ? 1'b0 : (m_p[i] | s[i]);
    if (mr) m_oen = 0; else if (cv && f == 2'b01) m_oen = 1;
    if (mr) m_last = 0; else if (ctl_valid && ctl_word == 16'd2) m_last = 1;
    if (ctl_valid && ctl_word == 16'd4) m_lb = 1;
    if (ctl_valid && ctl_word == 16'd5) m_lb = 0;
    if (ctl_valid && ctl_word == 16'd6) m_rly = 1;
    if (ctl_valid && ctl_word == 16'd7) m_rly = 0;
    if (ctl_valid && ctl_word == 16'h0400) m_dis = 1;
    if (ctl_valid && ctl_word == 16'h0200) m_dis = 0;
    if (!net_ready) m_wd = 1;
    else if (ctl_valid && ctl_word == 16'd3) m_wd = 0;
    m_stop = mr;
  endtask

  task automatic compare_all();
    check("R2 wake", {15'd0, wake}, {15'd0, |m_p});
    check("R2 disp", {14'd0, disp}, {14'd0, exp_disp(m_p)});
    check("R1 out_en", {15'd0, out_en}, {15'd0, m_oen});
    check("R5 xfer_stop", {15'd0, xfer_stop}, {15'd0, m_stop});
    check("R6 last_word", {15'd0, last_word}, {15'd0, m_last});
    check("R7 loopback", {15'd0, loopback}, {15'd0, m_lb});
    check("R7 host_relay", {15'd0, host_relay}, {15'd0, m_rly});
    check("R8 discard", {15'd0, discard}, {15'd0, m_dis});
    check("R10 stat_word", stat_word, exp_stat(m_wd, net_ready, m_rly));
  endtask

  task automatic idle();
    start_valid = 0; ctl_valid = 0; wake_clr = 0; out_req = 0;
    out_clr = 0; in_word = 0; in_ack = 0;
    start_word = 0; ctl_word = 0;
  endtask

  // inputs are set after a falling edge; apply them for one rising edge
  task automatic step();
    model_step();
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);
    idle();
  endtask

  task automatic ctl(logic [15:0] w);
    ctl_valid = 1; ctl_word = w; step();
  endtask

  task automatic start(logic [1:0] f);
    start_valid = 1; start_word = {5'd0, f, 9'd0}; step();
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1978));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R12 reset state
    check("R12 wake", {15'd0, wake}, 16'd0);
    check("R12 out_en", {15'd0, out_en}, 16'd0);
    check("R10 reset stat", stat_word, 16'hFFF9);
    compare_all();

    // R1/R2 priority across all sources
    start(2'b10);
    check("R1 input start", {14'd0, disp}, 16'd0);
    check("R1 wake", {15'd0, wake}, 16'd1);
    start(2'b11);
    check("R1 control", {14'd0, disp}, 16'd1);
    start(2'b01);
    check("R1 output", {14'd0, disp}, 16'd2);
    in_word = 1; step();
    check("R2 input data top", {14'd0, disp}, 16'd3);
    in_ack = 1; step();
    check("R4 in_ack", {14'd0, disp}, 16'd2);
    wake_clr = 1; step();
    check("R3 output survives", {15'd0, wake}, 16'd1);
    check("R3 disp", {14'd0, disp}, 16'd2);
    out_clr = 1; step();
    check("R3 all clear", {15'd0, wake}, 16'd0);
    out_req = 1; step();
    check("R4 out_req while enabled", {14'd0, disp}, 16'd2);
    out_req = 1; out_clr = 1; step();
    check("R4 clear wins", {15'd0, wake}, 16'd0);
    start(2'b00);
    check("R1 code 00 nothing", {15'd0, wake}, 16'd0);

    // R5 master reset
    ctl(16'd6); ctl(16'd4); ctl(16'h0400); ctl(16'd2);
    start(2'b11); in_word = 1; step();
    ctl(16'd1);
    check("R5 wake cleared", {15'd0, wake}, 16'd0);
    check("R5 out_en cleared", {15'd0, out_en}, 16'd0);
    check("R5 relay kept", {15'd0, host_relay}, 16'd1);
    check("R5 stop pulse", {15'd0, xfer_stop}, 16'd1);
    step();
    check("R5 stop one cycle", {15'd0, xfer_stop}, 16'd0);
    out_req = 1; step();
    check("R4 out_req gated", {15'd0, wake}, 16'd0);

    // R11 undefined words
    ctl(16'd2);
    ctl(16'o0010); ctl(16'o3000); ctl(16'hFFFF); ctl(16'h0600); ctl(16'd0);
    check("R11 loopback", {15'd0, loopback}, 16'd1);
    check("R11 discard", {15'd0, discard}, 16'd1);
    check("R11 last_word", {15'd0, last_word}, 16'd1);
    check("R11 wake", {15'd0, wake}, 16'd0);
    ctl(16'd5); ctl(16'd7); ctl(16'h0200);
    check("R8 discard off", {15'd0, discard}, 16'd0);

    // R9 sticky down flag
    net_ready = 0; step();
    check("R9 set", stat_word, 16'hFFFF);
    ctl_valid = 1; ctl_word = 16'd3; step();
    net_ready = 1; #0;
    check("R9 no clear while down", stat_word, 16'hFFFD);
    step();
    check("R9 stays", stat_word, 16'hFFFD);
    ctl(16'd3);
    check("R9 cleared", stat_word, 16'hFFF9);

    // seeded random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      start_valid = ($urandom % 4) == 0;
      start_word  = 16'($urandom);
      ctl_valid   = ($urandom % 3) == 0;
      r = $urandom % 12;
      if (r < 8) ctl_word = 16'(r);
      else if (r == 8) ctl_word = 16'h0400;
      else if (r == 9) ctl_word = 16'h0200;
      else ctl_word = 16'($urandom);
      wake_clr  = ($urandom % 5) == 0;
      out_req   = ($urandom % 3) == 0;
      out_clr   = ($urandom % 6) == 0;
      in_word   = ($urandom % 5) == 0;
      in_ack    = ($urandom % 5) == 0;
      net_ready = ($urandom % 10) != 0;
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule